// File: doc/BRIEF.md
# Two-Channel Input Glitch Filter with Selectable Sample Rate

This block cleans up two slow external trigger or capture inputs before timer logic uses them. Each raw pin first passes through a two-flop synchronizer. When filtering is on, the synchronized level is sampled on a sampling tick. The filtered level moves only after three samples in a row agree. Ticks come either on every system clock or on every fourth clock. When filtering is off, the synchronized level goes straight to the output. Each channel gives a filtered level and one-cycle rising and falling edge strobes.

One byte-wide control register holds the settings for both channels: an enable bit and a rate select bit. A write that changes the rate, or that turns filtering on, starts a settling window of three sampling periods. During that window the sample history of every channel is reloaded from the current synchronized level and the ready output is low. Timer logic should not trust edges until ready returns high.

Top module: `pin_noise_filter`

## Requirements
- R1: The control register is 8 bits wide and resets to 0x00 (filter off, full rate). Bit 7 is the filter enable and bit 0 is the rate select (1 = one tick every 4 clocks). Bits 6..1 always read 0 and ignore writes. The read port always shows the current register value.
- R2: With bit 7 clear, the level output follows the pin through the two-flop synchronizer. A pin change that sets up before clock edge E0 shows on the level at edge E2.
- R3: With bit 7 set, the level changes only when the current sample and the two samples before it all show the new value. At full rate, a pin change that sets up before edge E0 shows on the level at edge E4. Between sampling ticks the level never changes.
- R4: With bit 0 set, samples are taken on every fourth clock only. A high pulse that lasts exactly 12 clocks is accepted, and one that lasts exactly 8 clocks is rejected.
- R5: With filtering on, a pulse no wider than two sampling periods never reaches the level output. This means 2 clocks at full rate and 8 clocks at the divided rate.
- R6: A write that changes bit 0, or that sets bit 7 while it was clear, drives ready low from the next clock. Ready stays low for three sampling ticks, so at full rate it is high again 3 clocks later. A write that does neither leaves ready high.
- R7: The restart write reloads each channel's sample history with its current synchronized level. If that level differs from the filtered level, the filtered level takes it on the next tick. The edge strobe then fires while ready is still low.
- R8: The rise strobe and the fall strobe are each one clock wide. They never fire together. Rise fires in the cycle where the level first reads 1, and fall in the cycle where it first reads 0.
- R9: The two channels are independent. A pulse on one pin produces no strobe on the other, and simultaneous pulses give one strobe on each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| pin_in | input | 2 | Raw asynchronous channel inputs |
| lvl_out | output | 2 | Filtered level per channel |
| rise_out | output | 2 | One-cycle rising-edge strobe per channel |
| fall_out | output | 2 | One-cycle falling-edge strobe per channel |
| ready | output | 1 | High when the filter history is valid |

## Verification
Two things can land on the same clock: a restart write and a filtered edge. The restart write reloads the history and starts the settling window. In that same cycle, the reloaded history can let a level change through on the next tick. The bench raises a pin and, two clocks later, before the filter has accepted the change, writes a new rate select. That write reloads the history with the already-high synchronized level. The bench then expects exactly one rise strobe, seen while ready is still low, and a filtered level of 1 afterwards.

// File: rtl/nf_pkg.sv
package nf_pkg;

    localparam int CFG_W   = 8;
    localparam int EN_BIT  = 7;
    localparam int SEL_BIT = 0;

    typedef struct packed {
        logic en;
        logic sel;
    } nf_ctrl_t;

endpackage

// File: rtl/nf_rate_gen.sv
module nf_rate_gen #(
    parameter int DIV    = 4,
    parameter int SETTLE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic restart,
    output logic tick,
    output logic ready
);

    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int CW = $clog2(SETTLE + 1);

    typedef struct packed {
        logic [DW-1:0] div;
        logic [CW-1:0] cnt;
    } rg_state_t;

    rg_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.div = st_q.div + DW'(1);
        tick     = sel ? (st_q.div == DW'(DIV - 1)) : 1'b1;
        if (restart) begin
            st_d.cnt = CW'(SETTLE);
        end else if (tick && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready = (st_q.cnt == '0);

    // R4
    div_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && tick && !restart) |=> !tick);

    // R6
    restart_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !ready);

endmodule

// File: rtl/nf_channel.sv
module nf_channel #(
    parameter int SYNC  = 2,
    parameter int NSAMP = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic en,
    input  logic tick,
    input  logic clear,
    output logic level,
    output logic rise,
    output logic fall
);

    typedef struct packed {
        logic [SYNC-1:0]  sync;
        logic [NSAMP-1:0] hist;
        logic             level;
        logic             prev;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic             synced;
    logic [NSAMP-1:0] hist_sh;

    always_comb begin
        st_d     = st_q;
        synced   = st_q.sync[SYNC-1];
        hist_sh  = {st_q.hist[NSAMP-2:0], synced};
        st_d.sync = {st_q.sync[SYNC-2:0], pin};
        if (clear) begin
            st_d.hist = {NSAMP{synced}};
        end else if (tick) begin
            st_d.hist = hist_sh;
        end
        if (!en) begin
            st_d.level = synced;
        end else if (tick && !clear) begin
            if (&hist_sh) begin
                st_d.level = 1'b1;
            end else if (~|hist_sh) begin
                st_d.level = 1'b0;
            end
        end else if (tick && clear) begin
            st_d.level = st_q.level;
        end
        st_d.prev = st_q.level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.level;
    assign rise  = st_q.level & ~st_q.prev;
    assign fall  = ~st_q.level & st_q.prev;

    // R8
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall));

    // R8
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

    // R3
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(level));

endmodule

// File: rtl/pin_noise_filter.sv
module pin_noise_filter #(
    parameter int NCH   = 2,
    parameter int DIV   = 4,
    parameter int NSAMP = 3,
    parameter int SYNC  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [7:0]     cfg_wdata,
    output logic [7:0]     cfg_rdata,
    input  logic [NCH-1:0] pin_in,
    output logic [NCH-1:0] lvl_out,
    output logic [NCH-1:0] rise_out,
    output logic [NCH-1:0] fall_out,
    output logic           ready
);

    import nf_pkg::*;

    nf_ctrl_t ctrl_d, ctrl_q;
    logic     restart;
    logic     tick;

    always_comb begin
        ctrl_d  = ctrl_q;
        restart = 1'b0;
        if (cfg_we) begin
            ctrl_d.en  = cfg_wdata[EN_BIT];
            ctrl_d.sel = cfg_wdata[SEL_BIT];
            restart    = (cfg_wdata[SEL_BIT] != ctrl_q.sel) ||
                         (cfg_wdata[EN_BIT] && !ctrl_q.en);
        end
        cfg_rdata          = '0;
        cfg_rdata[EN_BIT]  = ctrl_q.en;
        cfg_rdata[SEL_BIT] = ctrl_q.sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    nf_rate_gen #(.DIV(DIV), .SETTLE(NSAMP)) u_rate (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (ctrl_q.sel),
        .restart (restart),
        .tick    (tick),
        .ready   (ready)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        nf_channel #(.SYNC(SYNC), .NSAMP(NSAMP)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pin_in[c]),
            .en    (ctrl_q.en),
            .tick  (tick),
            .clear (restart),
            .level (lvl_out[c]),
            .rise  (rise_out[c]),
            .fall  (fall_out[c])
        );
    end

    // R1
    cfg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata[EN_BIT] == $past(cfg_wdata[EN_BIT])) &&
                   (cfg_rdata[SEL_BIT] == $past(cfg_wdata[SEL_BIT])));

    // R1
    cfg_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[6:1] == 6'd0);

    // R8
    rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rise_out & ~lvl_out)) == 1'b0);

endmodule

// File: tb/pin_noise_filter_test.sv
module pin_noise_filter_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    // {cfg, pulse width, expected rises on channel 0}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'h00, 8'd1,  8'd1},   // R2 bypass passes a 1-clock pulse
        {8'h80, 8'd2,  8'd0},   // R5 full rate, 2 clocks rejected
        {8'h80, 8'd3,  8'd1},   // R3 full rate, 3 clocks accepted
        {8'h81, 8'd8,  8'd0},   // R5 divided, 8 clocks rejected
        {8'h81, 8'd12, 8'd1},   // R4 divided, 12 clocks accepted
        {8'h80, 8'd10, 8'd1},   // R3 full rate, long pulse
        {8'h01, 8'd2,  8'd1},   // R2 bypass at divided select
        {8'h80, 8'd1,  8'd0}    // R5 full rate, 1 clock rejected
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic [1:0] pin_in = 2'b00;
    logic [1:0] lvl_out, rise_out, fall_out;
    logic       ready;

    int nchk = 0;
    int nfail = 0;
    int rc0 = 0, fc0 = 0, rc1 = 0;
    logic cnt_clr = 1'b0;
    bit done = 1'b0;

    pin_noise_filter uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .pin_in(pin_in), .lvl_out(lvl_out),
        .rise_out(rise_out), .fall_out(fall_out), .ready(ready)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        if (cnt_clr) begin
            rc0 = 0; fc0 = 0; rc1 = 0;
        end else begin
            rc0 = rc0 + int'(rise_out[0]);
            fc0 = fc0 + int'(fall_out[0]);
            rc1 = rc1 + int'(rise_out[1]);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 40 && !ready; i++) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    task automatic clear_counts();
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        bit seen;
        logic rdy_at_rise;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(cfg_rdata == 8'h00, "R1 reset cfg", cfg_rdata, 0);
        chk(ready == 1'b1, "R6 reset ready", ready, 1);
        chk(lvl_out == 2'b00, "R2 reset level", lvl_out, 0);

        // R1 readback and unused bits
        wr(8'hFF);
        chk(cfg_rdata == 8'h81, "R1 readback FF", cfg_rdata, 8'h81);
        wr(8'h7E);
        chk(cfg_rdata == 8'h00, "R1 readback 7E", cfg_rdata, 0);
        wait_ready();

        // vector table
        for (int v = 0; v < NVEC; v++) begin
            wr(VEC[v][23:16]);
            wait_ready();
            clear_counts();
            pin_in[0] = 1'b1;
            repeat (int'(VEC[v][15:8])) @(negedge clk);
            pin_in[0] = 1'b0;
            repeat (40) @(negedge clk);
            chk(rc0 == int'(VEC[v][7:0]), "R3/R4/R5 rise count", rc0, int'(VEC[v][7:0]));
            chk(fc0 == rc0, "R8 fall count", fc0, rc0);
            chk(rc1 == 0, "R9 quiet channel", rc1, 0);
            chk(lvl_out[0] == 1'b0, "R3 level back low", lvl_out[0], 0);
        end

        // R6 ready timing at full rate
        wr(8'h00);
        wait_ready();
        wr(8'h80);
        chk(ready == 1'b0, "R6 ready low +1", ready, 0);
        @(negedge clk);
        chk(ready == 1'b0, "R6 ready low +2", ready, 0);
        @(negedge clk);
        chk(ready == 1'b0, "R6 ready low +3", ready, 0);
        @(negedge clk);
        chk(ready == 1'b1, "R6 ready high +4", ready, 1);
        wr(8'h80);
        chk(ready == 1'b1, "R6 no-change write", ready, 1);
        repeat (8) @(negedge clk);

        // R3 latency at full rate
        pin_in[0] = 1'b1;
        repeat (4) @(negedge clk);
        chk(lvl_out[0] == 1'b0, "R3 level before E4", lvl_out[0], 0);
        @(negedge clk);
        chk(lvl_out[0] == 1'b1, "R3 level at E4", lvl_out[0], 1);
        chk(rise_out[0] == 1'b1, "R8 rise with level", rise_out[0], 1);
        @(negedge clk);
        chk(rise_out[0] == 1'b0, "R8 rise one cycle", rise_out[0], 0);
        pin_in[0] = 1'b0;
        repeat (10) @(negedge clk);

        // R2 latency in bypass
        wr(8'h00);
        repeat (8) @(negedge clk);
        pin_in[0] = 1'b1;
        repeat (2) @(negedge clk);
        chk(lvl_out[0] == 1'b0, "R2 level before E2", lvl_out[0], 0);
        @(negedge clk);
        chk(lvl_out[0] == 1'b1, "R2 level at E2", lvl_out[0], 1);
        pin_in[0] = 1'b0;
        repeat (8) @(negedge clk);

        // R9 both channels together
        wr(8'h80);
        wait_ready();
        clear_counts();
        pin_in = 2'b11;
        repeat (5) @(negedge clk);
        pin_in = 2'b00;
        repeat (20) @(negedge clk);
        chk(rc0 == 1, "R9 channel 0 rise", rc0, 1);
        chk(rc1 == 1, "R9 channel 1 rise", rc1, 1);

        // R7 restart coinciding with a pending edge
        clear_counts();
        pin_in[0] = 1'b1;
        repeat (2) @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = 8'h81;
        @(negedge clk);
        cfg_we = 1'b0;
        seen = 1'b0;
        rdy_at_rise = 1'b1;
        for (int i = 0; i < 10; i++) begin
            if (!seen && rise_out[0]) begin
                seen = 1'b1;
                rdy_at_rise = ready;
            end
            @(negedge clk);
        end
        chk(seen, "R7 rise in window", int'(seen), 1);
        chk(rdy_at_rise == 1'b0, "R7 ready low at rise", rdy_at_rise, 0);
        chk(lvl_out[0] == 1'b1, "R7 level settled", lvl_out[0], 1);
        pin_in[0] = 1'b0;
        repeat (30) @(negedge clk);

        summary();
    end

endmodule